// File: doc/BRIEF.md
# Keypad Button Status Register

This block sits on a byte-wide register bus. It samples ten push buttons and reports them as a 10-bit status word in which a pressed button reads as 0. Each raw button line is registered twice to remove metastability. Combinations of opposite directions that the hardware cannot produce are then removed, and the result is inverted and split across two byte offsets.

A 16-bit keypad control register sits at the two offsets that follow the status word. Each of its bytes can be written on its own and read back. The block does no debouncing and raises no interrupt. Software polls the status offsets. Reads are combinational from registered state. Writes take effect at the clock edge where the write enable is seen.

Top module: `kp_status_top`

## Requirements
- R1: Button index k (0 to 7) is reported in bit k of the byte at offset 0. Buttons 8 and 9 are reported in bits 0 and 1 of the byte at offset 1. The order of the buttons is: 0 and 1 face buttons, 2 select, 3 start, 4 right, 5 left, 6 up, 7 down, 8 and 9 shoulder buttons.
- R2: Status bits are inverted: a pressed button (input 1) reads as 0 and a released button reads as 1. Bits 7:2 at offset 1 always read as 0.
- R3: When up (index 6) and down (index 7) are both pressed, both are reported as released.
- R4: When right (index 4) and left (index 5) are both pressed, both are reported as released.
- R5: A change on a button input shows in the status after exactly two rising clock edges.
- R6: A write to offset 2 replaces control bits 7:0 only. A write to offset 3 replaces control bits 15:8 only. The other byte keeps its value.
- R7: A read at offset 2 returns control bits 7:0, and a read at offset 3 returns control bits 15:8.
- R8: Writes to offsets 0 and 1 change neither the status nor the control register.
- R9: After reset the control register is 0 and every button reads as released.
- R10: Offsets 4 to 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_raw | input | 10 | Raw button levels, 1 = pressed, index order as in R1 |
| bus_addr | input | 3 | Byte offset of the access |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| bus_wr_data | input | 8 | Write data byte |
| bus_rd_data | output | 8 | Read data byte for the current offset |

## Verification
The hardest case to reach is a conflicting direction pair arriving on the same edge as a change to an unrelated button, while a byte of the control register is being written. That is where the synchroniser delay, the filter and the read mux all meet. The stimulus drives the button lines and the bus in the same cycles. It rotates the read offset every cycle, so that both status bytes and both control bytes are compared against the delayed model during the transitions, and not only once the inputs have settled.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int KP_KEYS   = 10;
  localparam int KP_STAT_W = 16;
  localparam int KP_RIGHT  = 4;
  localparam int KP_LEFT   = 5;
  localparam int KP_UP     = 6;
  localparam int KP_DOWN   = 7;

  // Remove physically impossible opposite-direction pairs.
  function automatic logic [KP_KEYS-1:0] kp_suppress(input logic [KP_KEYS-1:0] pressed);
    logic [KP_KEYS-1:0] res;
    res = pressed;
    if (pressed[KP_UP] && pressed[KP_DOWN]) begin
      res[KP_UP]   = 1'b0;
      res[KP_DOWN] = 1'b0;
    end
    if (pressed[KP_RIGHT] && pressed[KP_LEFT]) begin
      res[KP_RIGHT] = 1'b0;
      res[KP_LEFT]  = 1'b0;
    end
    return res;
  endfunction

  // Active-low status word, unused upper bits zero.
  function automatic logic [KP_STAT_W-1:0] kp_status_word(input logic [KP_KEYS-1:0] filtered);
    logic [KP_STAT_W-1:0] w;
    w = '0;
    w[KP_KEYS-1:0] = ~filtered;
    return w;
  endfunction
endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int WIDTH  = 10,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        if (s == 0) stage_q[s] <= d;
        else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/kp_ctrl_reg.sv
module kp_ctrl_reg #(
  parameter int CTRL_W = 16,
  parameter int ADDR_W = 3,
  parameter int BASE   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CTRL_W/8-1:0] lane_we
);
  localparam int LANES = CTRL_W / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = wr_en && (addr == ADDR_W'(BASE + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ctrl_q[i*8 +: 8] <= 8'h00;
      else if (lane_we[i]) ctrl_q[i*8 +: 8] <= wr_data;
    end
  end
endmodule

// File: rtl/kp_read_mux.sv
module kp_read_mux #(
  parameter int STAT_W = 16,
  parameter int CTRL_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [STAT_W-1:0] stat_word,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic [7:0]        rd_data
);
  localparam int STAT_BYTES = STAT_W / 8;
  localparam int CTRL_BYTES = CTRL_W / 8;

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < STAT_BYTES; i++)
      if (addr == ADDR_W'(i)) rd_data = stat_word[i*8 +: 8];
    for (int j = 0; j < CTRL_BYTES; j++)
      if (addr == ADDR_W'(STAT_BYTES + j)) rd_data = ctrl_word[j*8 +: 8];
  end
endmodule

// File: rtl/kp_status_top.sv
module kp_status_top #(
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_W      = 16,
  parameter int ADDR_W      = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [kp_pkg::KP_KEYS-1:0] btn_raw,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr_en,
  input  logic [7:0]                 bus_wr_data,
  output logic [7:0]                 bus_rd_data
);
  import kp_pkg::*;

  localparam int STAT_BYTES = KP_STAT_W / 8;

  logic [KP_KEYS-1:0]   sync_q;
  logic [KP_KEYS-1:0]   filt_pressed;
  logic [KP_STAT_W-1:0] stat_word;
  logic [CTRL_W-1:0]    ctrl_q;
  logic [CTRL_W/8-1:0]  ctrl_lane_we;

  kp_sync #(.WIDTH(KP_KEYS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(btn_raw), .q(sync_q)
  );

  assign filt_pressed = kp_suppress(sync_q);
  assign stat_word    = kp_status_word(filt_pressed);

  kp_ctrl_reg #(.CTRL_W(CTRL_W), .ADDR_W(ADDR_W), .BASE(STAT_BYTES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr_en),
    .wr_data(bus_wr_data), .ctrl_q(ctrl_q), .lane_we(ctrl_lane_we)
  );

  kp_read_mux #(.STAT_W(KP_STAT_W), .CTRL_W(CTRL_W), .ADDR_W(ADDR_W)) mux_i (
    .addr(bus_addr), .stat_word(stat_word), .ctrl_word(ctrl_q), .rd_data(bus_rd_data)
  );
endmodule

// File: rtl/kp_status_checker.sv
module kp_status_checker #(
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_W      = 16,
  parameter int ADDR_W      = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [9:0]        btn_raw,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr_en,
  input logic [7:0]        bus_wr_data,
  input logic [7:0]        bus_rd_data,
  input logic [9:0]        sync_q,
  input logic [9:0]        filt_pressed,
  input logic [CTRL_W-1:0] ctrl_q
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_HIGH_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(1)) |-> (bus_rd_data[7:2] == 6'd0)); // R2

  AST_NO_VERTICAL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(filt_pressed[6] && filt_pressed[7])); // R3

  AST_NO_HORIZONTAL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(filt_pressed[4] && filt_pressed[5])); // R4

  if (SYNC_STAGES == 2) begin : g_lat
    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2) |-> (sync_q == $past(btn_raw, 2))); // R5
  end

  AST_CTRL_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == ADDR_W'(2)) |=>
      (ctrl_q[7:0] == $past(bus_wr_data) && ctrl_q[15:8] == $past(ctrl_q[15:8]))); // R6

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en && (bus_addr == ADDR_W'(2) || bus_addr == ADDR_W'(3))) |=> $stable(ctrl_q)); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= ADDR_W'(4)) |-> (bus_rd_data == 8'h00)); // R10
endmodule

bind kp_status_top kp_status_checker #(
  .SYNC_STAGES(SYNC_STAGES), .CTRL_W(CTRL_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .bus_addr(bus_addr),
  .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data),
  .sync_q(sync_q), .filt_pressed(filt_pressed), .ctrl_q(ctrl_q)
);

// File: tb/kp_status_tb.sv
module kp_status_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] btn_raw = '0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr_en = 1'b0;
  logic [7:0] bus_wr_data = '0;
  logic [7:0] bus_rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R9";

  logic [9:0]  hist[$];
  logic [15:0] m_ctrl = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  kp_status_top dut_i (
    .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .bus_addr(bus_addr),
    .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data)
  );

  initial begin
    hist.push_back(10'd0);
    hist.push_back(10'd0);
  end

  // Reference model, advanced on every rising edge.
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      hist.push_back(10'd0);
      m_ctrl = 16'h0000;
    end else begin
      hist.push_back(btn_raw);
      if (bus_wr_en && bus_addr == 3'd2) m_ctrl = {m_ctrl[15:8], bus_wr_data};
      if (bus_wr_en && bus_addr == 3'd3) m_ctrl = {bus_wr_data, m_ctrl[7:0]};
    end
    while (hist.size() > 4) void'(hist.pop_front());
  end

  function automatic int model_status();
    int p;
    p = int'(hist[hist.size()-2]);
    if ((p & 'hC0) == 'hC0) p = p & ~'hC0;
    if ((p & 'h30) == 'h30) p = p & ~'h30;
    return (~p) & 'h3FF;
  endfunction

  function automatic logic [7:0] model_read(input logic [2:0] a);
    int s;
    s = model_status();
    case (a)
      3'd0: return 8'(s & 'hFF);
      3'd1: return 8'(s >> 8);
      3'd2: return m_ctrl[7:0];
      3'd3: return m_ctrl[15:8];
      default: return 8'h00;
    endcase
  endfunction

  // Check the current read, then drive the next cycle's inputs.
  task automatic step(input logic [9:0] b, input logic [2:0] a,
                      input logic we, input logic [7:0] d);
    logic [7:0] exp;
    @(negedge clk);
    exp = model_read(bus_addr);
    checks++;
    if (bus_rd_data !== exp) begin
      errors++;
      $display("FAIL %s offset %0d: actual %02h expected %02h", cur_req, bus_addr, bus_rd_data, exp);
    end
    btn_raw = b; bus_addr = a; bus_wr_en = we; bus_wr_data = d;
  endtask

  task automatic hold(input logic [9:0] b, input int n);
    for (int i = 0; i < n; i++) step(b, 3'(i), 1'b0, 8'h00);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state, all offsets
    cur_req = "R9";
    hold(10'h000, 8);
    // R1: walking single press, R2 inversion
    cur_req = "R1";
    for (int k = 0; k < 10; k++) hold(10'(1 << k), 4);
    cur_req = "R2";
    hold(10'h300, 4);
    hold(10'h3FF, 4);
    // R3: up+down together, with other keys changing
    cur_req = "R3";
    hold(10'h0C0, 4);
    hold(10'h0C1, 4);
    hold(10'h2C8, 4);
    // R4: right+left together
    cur_req = "R4";
    hold(10'h030, 4);
    hold(10'h0F0, 4);
    hold(10'h172, 4);
    // R5: latency, status polled every cycle on offset 0 across edges
    cur_req = "R5";
    for (int i = 0; i < 6; i++) step(10'(i * 37), 3'd0, 1'b0, 8'h00);
    hold(10'h000, 4);
    // R6: byte lanes independent, read back each (R7)
    cur_req = "R6";
    step(10'h000, 3'd2, 1'b1, 8'hA5);
    step(10'h0C4, 3'd3, 1'b0, 8'h00);
    step(10'h0C4, 3'd3, 1'b1, 8'h3C);
    step(10'h030, 3'd2, 1'b0, 8'h00);
    cur_req = "R7";
    hold(10'h005, 8);
    step(10'h005, 3'd2, 1'b1, 8'h11);
    step(10'h005, 3'd2, 1'b0, 8'h00);
    step(10'h005, 3'd3, 1'b0, 8'h00);
    // R8: writes to status offsets ignored
    cur_req = "R8";
    step(10'h001, 3'd0, 1'b1, 8'h00);
    step(10'h001, 3'd1, 1'b1, 8'hFF);
    step(10'h001, 3'd0, 1'b0, 8'h00);
    step(10'h001, 3'd1, 1'b0, 8'h00);
    step(10'h001, 3'd2, 1'b0, 8'h00);
    step(10'h001, 3'd3, 1'b0, 8'h00);
    // R10: unmapped offsets
    cur_req = "R10";
    for (int a = 4; a < 8; a++) step(10'h000, 3'(a), 1'b1, 8'hEE);
    hold(10'h000, 8);
    step(10'h000, 3'd0, 1'b0, 8'h00);
    finish_run();
  end
endmodule